// File: doc/BRIEF.md
# Relative Branch Condition Unit

This unit resolves relative branches in an 8-bit processor core. In each cycle with a request, it receives the opcode byte, the prefix byte that came before it, the 8-bit displacement, the condition-code bits, the level of the external interrupt line, the tested memory byte for bit-test forms, and the address of the instruction that follows the branch. One clock later it reports three things: whether the opcode was a relative branch, whether that branch is taken, and the address where execution continues.

The unit resolves two groups of branches. The first group is the sixteen short conditional branches, opcodes 0x20 to 0x2F. Their low nibble picks a test on carry, zero, negative and overflow, including the signed and unsigned comparisons built from those flags. A 0x90 prefix replaces six of those tests with tests on half-carry, on the interrupt mask and on the interrupt line. The second group is the bit-test branches, which use a 0x72 prefix. For these, the memory byte has already been fetched by the caller.

The unit only reports a decision. It never writes any flag, and it leaves pipeline redirection to the surrounding core.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `res_valid`=0, `res_branch`=0, `res_taken`=0 and `res_target`=0.
- R2: The results for a request on `req_valid` appear exactly one cycle later with `res_valid`=1. `res_valid` is 0 in a cycle that follows no request.
- R3: When `req_prefix`=0x00 (no prefix) and the opcode is 0x2N, the branch is taken for these values of N: 0 always; 1 never; 2 when C=0 and Z=0; 3 when C=1 or Z=1; 4 when C=0; 5 when C=1; 6 when Z=0; 7 when Z=1.
- R4: With no prefix, the branch is taken for these values of N: 8 when V=0; 9 when V=1; A when N=0; B when N=1; C when Z=0 and N=V; D when Z=1 or N≠V; E when N=V; F when N≠V.
- R5: With prefix 0x90, six slots use other tests. Slot 8 is taken when H=0 and slot 9 when H=1. Slot C is taken when the low interrupt-mask bit I0 is 0, and slot D when I0 is 1. Slot E is taken when `irq_line` is 0, and slot F when it is 1.
- R6: With prefix 0x90, slots 0 to 7, A and B use the same tests as with no prefix.
- R7: With prefix 0x72, an opcode 0b0000_bbb_v is a bit-test branch on bit bbb of `test_byte`. When v=0 it is taken if that bit is 1. When v=1 it is taken if that bit is 0.
- R8: A taken branch targets `next_pc` plus the sign-extended displacement, modulo 2^24. A branch that is not taken reports `next_pc`.
- R9: Any other combination of prefix and opcode reports `res_branch`=0 and `res_taken`=0, and reports `next_pc` as the target. This includes prefix 0x72 with 0x2N, prefix 0x90 with 0x0N, and prefix 0x92 with any opcode.
- R10: `cc_in` bit positions are C=0, Z=1, N=2, I0=3, H=4, I1=5 and V=6. No bit of `cc_in` other than the one named by the selected test changes the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_prefix | input | 8 | Prefix byte, 0x00 when none |
| req_opcode | input | 8 | Opcode byte |
| req_disp | input | 8 | Signed displacement |
| cc_in | input | 7 | Condition-code bits |
| irq_line | input | 1 | External interrupt line level |
| test_byte | input | 8 | Memory byte for bit-test forms |
| next_pc | input | 24 | Address of the instruction after the branch |
| res_valid | output | 1 | Results valid |
| res_branch | output | 1 | Opcode was a relative branch |
| res_taken | output | 1 | Branch taken |
| res_target | output | 24 | Continuation address |

## Verification
The hardest case to reach from the ports is a wrong choice between a prefixed slot and its unprefixed meaning. That mistake stays hidden whenever both tests happen to agree. To expose it, each 0x90 vector uses a flag word or interrupt-line level that makes the reassigned test and the plain test give opposite answers. One example is slot C with N=1 and V=0 but I0 clear. Another is slot C with only the unused high mask bit set, so that a unit reading the wrong mask bit fails. The address wrap is reached by placing `next_pc` at both ends of the 24-bit range with displacements of +1 and -1.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam logic [7:0] PFX_NONE = 8'h00;
    localparam logic [7:0] PFX_ALT  = 8'h90;
    localparam logic [7:0] PFX_BIT  = 8'h72;

    localparam logic [3:0] GRP_SHORT = 4'h2;
    localparam logic [3:0] GRP_BIT   = 4'h0;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SHORT = 2'd1,
        KIND_BIT   = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic v;
        logic mask_hi;
        logic h;
        logic mask_lo;
        logic n;
        logic z;
        logic c;
    } cc_t;

    typedef struct packed {
        br_kind_e   kind;
        logic       alt;
        logic [3:0] slot;
        logic [2:0] bit_sel;
        logic       bit_pol;
    } dec_t;

    function automatic cc_t unpack_cc(input logic [6:0] raw);
        cc_t f;
        f.c       = raw[0];
        f.z       = raw[1];
        f.n       = raw[2];
        f.mask_lo = raw[3];
        f.h       = raw[4];
        f.mask_hi = raw[5];
        f.v       = raw[6];
        return f;
    endfunction

    function automatic logic is_alt_slot(input logic [3:0] s);
        return (s == 4'h8) || (s == 4'h9) || (s[3:2] == 2'b11);
    endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [7:0] prefix,
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec.kind    = KIND_NONE;
        dec.alt     = 1'b0;
        dec.slot    = opcode[3:0];
        dec.bit_sel = opcode[3:1];
        dec.bit_pol = opcode[0];
        if (opcode[7:4] == GRP_SHORT && (prefix == PFX_NONE || prefix == PFX_ALT)) begin
            dec.kind = KIND_SHORT;
            dec.alt  = (prefix == PFX_ALT) && is_alt_slot(opcode[3:0]);
        end else if (opcode[7:4] == GRP_BIT && prefix == PFX_BIT) begin
            dec.kind = KIND_BIT;
        end
    end
endmodule

// File: rtl/bcu_cond.sv
module bcu_cond
    import bcu_pkg::*;
(
    input  cc_t        flags,
    input  logic [3:0] slot,
    input  logic       alt,
    input  logic       irq_line,
    output logic       cond
);
    logic sgn_ok;
    logic unused_mask_hi;

    assign unused_mask_hi = flags.mask_hi;
    assign sgn_ok = ~(flags.n ^ flags.v);

    always_comb begin
        unique case (slot)
            4'h0: cond = 1'b1;
            4'h1: cond = 1'b0;
            4'h2: cond = ~flags.c & ~flags.z;
            4'h3: cond = flags.c | flags.z;
            4'h4: cond = ~flags.c;
            4'h5: cond = flags.c;
            4'h6: cond = ~flags.z;
            4'h7: cond = flags.z;
            4'h8: cond = alt ? ~flags.h : ~flags.v;
            4'h9: cond = alt ? flags.h : flags.v;
            4'hA: cond = ~flags.n;
            4'hB: cond = flags.n;
            4'hC: cond = alt ? ~flags.mask_lo : (~flags.z & sgn_ok);
            4'hD: cond = alt ? flags.mask_lo : (flags.z | ~sgn_ok);
            4'hE: cond = alt ? ~irq_line : sgn_ok;
            default: cond = alt ? irq_line : ~sgn_ok;
        endcase
    end
endmodule

// File: rtl/bcu_bittest.sv
module bcu_bittest #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [SEL_W-1:0]  sel,
    input  logic              pol,
    output logic              cond
);
    assign cond = data[sel] ^ pol;
endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
    parameter int PC_W   = 24,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W;
    logic [PC_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    assign target = take ? (base + disp_ext) : base;
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int PC_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [7:0]      req_prefix,
    input  logic [7:0]      req_opcode,
    input  logic [7:0]      req_disp,
    input  logic [6:0]      cc_in,
    input  logic            irq_line,
    input  logic [7:0]      test_byte,
    input  logic [PC_W-1:0] next_pc,
    output logic            res_valid,
    output logic            res_branch,
    output logic            res_taken,
    output logic [PC_W-1:0] res_target
);
    dec_t            dec;
    cc_t             flags;
    logic            short_ok;
    logic            bit_ok;
    logic            take;
    logic [PC_W-1:0] tgt;

    assign flags = unpack_cc(cc_in);

    bcu_decode u_dec (
        .prefix (req_prefix),
        .opcode (req_opcode),
        .dec    (dec)
    );

    bcu_cond u_cond (
        .flags    (flags),
        .slot     (dec.slot),
        .alt      (dec.alt),
        .irq_line (irq_line),
        .cond     (short_ok)
    );

    bcu_bittest #(.DATA_W(8)) u_bit (
        .data (test_byte),
        .sel  (dec.bit_sel),
        .pol  (dec.bit_pol),
        .cond (bit_ok)
    );

    always_comb begin
        unique case (dec.kind)
            KIND_SHORT: take = short_ok;
            KIND_BIT:   take = bit_ok;
            default:    take = 1'b0;
        endcase
    end

    bcu_target #(.PC_W(PC_W), .DISP_W(8)) u_tgt (
        .base   (next_pc),
        .disp   (req_disp),
        .take   (take),
        .target (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_branch <= 1'b0;
            res_taken  <= 1'b0;
            res_target <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_branch <= (dec.kind != KIND_NONE);
                res_taken  <= take;
                res_target <= tgt;
            end
        end
    end

    // R2: one-cycle latency
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    // R9: a non-branch is never taken
    p_nonbranch_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_branch) |-> !res_taken);
    // R8: the not-taken target is the fall-through address
    p_fallthru_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !take) |=> (res_target == $past(next_pc)));
    // R3: slot 0 always, slot 1 never
    p_always_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prefix == PFX_NONE && req_opcode == 8'h20) |=> res_taken);
    p_never_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_opcode == 8'h21) |=> !res_taken);
    // R7: bit-test outcome follows the selected bit and polarity
    p_bittest_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prefix == PFX_BIT && req_opcode[7:4] == 4'h0)
        |=> (res_taken == ($past(test_byte[req_opcode[3:1]]) ^ $past(req_opcode[0]))));
endmodule

// File: tb/sim_branch_cond_unit.sv
module sim_branch_cond_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_prefix, req_opcode, req_disp, test_byte;
    logic [6:0]  cc_in;
    logic        irq_line;
    logic [23:0] next_pc;
    logic        res_valid, res_branch, res_taken;
    logic [23:0] res_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_cond_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_prefix(req_prefix), .req_opcode(req_opcode), .req_disp(req_disp),
        .cc_in(cc_in), .irq_line(irq_line), .test_byte(test_byte),
        .next_pc(next_pc), .res_valid(res_valid), .res_branch(res_branch),
        .res_taken(res_taken), .res_target(res_target)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  pfx;
        logic [7:0]  op;
        logic [7:0]  disp;
        logic [6:0]  cc;
        logic        irq;
        logic [7:0]  tb;
        logic [23:0] npc;
        logic        br;
        logic        tk;
        logic [23:0] tgt;
    } vec_t;

    localparam int NV = 35;
    // cc layout: C=0 Z=1 N=2 I0=3 H=4 I1=5 V=6
    localparam vec_t VEC [NV] = '{
        {4'd3, 8'h00, 8'h20, 8'h05, 7'h00, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001005},
        {4'd3, 8'h00, 8'h21, 8'h05, 7'h7F, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd3, 8'h00, 8'h22, 8'h10, 7'h00, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001010},
        {4'd3, 8'h00, 8'h22, 8'h10, 7'h02, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd3, 8'h00, 8'h23, 8'hF0, 7'h01, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h000FF0},
        {4'd3, 8'h00, 8'h24, 8'h05, 7'h01, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd3, 8'h00, 8'h27, 8'h7F, 7'h02, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h00107F},
        {4'd3, 8'h00, 8'h26, 8'h05, 7'h02, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd4, 8'h00, 8'h28, 8'h80, 7'h00, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h000F80},
        {4'd4, 8'h00, 8'h29, 8'h02, 7'h40, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001002},
        {4'd4, 8'h00, 8'h2B, 8'h01, 7'h04, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001001},
        {4'd4, 8'h00, 8'h2C, 8'h03, 7'h44, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001003},
        {4'd4, 8'h00, 8'h2C, 8'h03, 7'h46, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd4, 8'h00, 8'h2D, 8'h04, 7'h04, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001004},
        {4'd4, 8'h00, 8'h2E, 8'h05, 7'h40, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd4, 8'h00, 8'h2F, 8'h06, 7'h40, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001006},
        {4'd5, 8'h90, 8'h28, 8'h08, 7'h40, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001008},
        {4'd5, 8'h90, 8'h29, 8'h08, 7'h10, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001008},
        {4'd5, 8'h90, 8'h2C, 8'h08, 7'h24, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001008},
        {4'd5, 8'h90, 8'h2D, 8'h08, 7'h08, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001008},
        {4'd5, 8'h90, 8'h2E, 8'h08, 7'h04, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001008},
        {4'd5, 8'h90, 8'h2F, 8'h08, 7'h04, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd5, 8'h90, 8'h2F, 8'h08, 7'h00, 1'b1, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001008},
        {4'd6, 8'h90, 8'h27, 8'h09, 7'h02, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b1, 24'h001009},
        {4'd6, 8'h90, 8'h2A, 8'h09, 7'h04, 1'b0, 8'h00, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd7, 8'h72, 8'h06, 8'h0A, 7'h00, 1'b0, 8'h08, 24'h001000, 1'b1, 1'b1, 24'h00100A},
        {4'd7, 8'h72, 8'h07, 8'h0A, 7'h00, 1'b0, 8'h08, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd7, 8'h72, 8'h0F, 8'h0B, 7'h00, 1'b0, 8'h7F, 24'h001000, 1'b1, 1'b1, 24'h00100B},
        {4'd7, 8'h72, 8'h00, 8'h0C, 7'h00, 1'b0, 8'hFE, 24'h001000, 1'b1, 1'b0, 24'h001000},
        {4'd8, 8'h00, 8'h20, 8'h01, 7'h00, 1'b0, 8'h00, 24'hFFFFFF, 1'b1, 1'b1, 24'h000000},
        {4'd8, 8'h00, 8'h20, 8'hFF, 7'h00, 1'b0, 8'h00, 24'h000000, 1'b1, 1'b1, 24'hFFFFFF},
        {4'd9, 8'h00, 8'h30, 8'h05, 7'h00, 1'b0, 8'h00, 24'h001000, 1'b0, 1'b0, 24'h001000},
        {4'd9, 8'h72, 8'h20, 8'h05, 7'h00, 1'b0, 8'h00, 24'h001000, 1'b0, 1'b0, 24'h001000},
        {4'd9, 8'h90, 8'h06, 8'h05, 7'h00, 1'b0, 8'hFF, 24'h001000, 1'b0, 1'b0, 24'h001000},
        {4'd9, 8'h92, 8'h20, 8'h05, 7'h00, 1'b0, 8'h00, 24'h001000, 1'b0, 1'b0, 24'h001000}
    };

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] pfx, input logic [7:0] op, input logic [7:0] d,
                         input logic [6:0] cc, input logic irq, input logic [7:0] tb,
                         input logic [23:0] npc);
        req_valid  = 1'b1;
        req_prefix = pfx;
        req_opcode = op;
        req_disp   = d;
        cc_in      = cc;
        irq_line   = irq;
        test_byte  = tb;
        next_pc    = npc;
    endtask

    task automatic idle();
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle();
        drive(8'h00, 8'h20, 8'h05, 7'h00, 1'b0, 8'h00, 24'h001000);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "valid", {23'd0, res_valid}, 24'd0);
        check("R1", "taken", {23'd0, res_taken}, 24'd0);
        check("R1", "target", res_target, 24'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2: no request, no result
        check("R2", "idle valid", {23'd0, res_valid}, 24'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].pfx, VEC[i].op, VEC[i].disp, VEC[i].cc, VEC[i].irq, VEC[i].tb, VEC[i].npc);
            @(negedge clk);
            check(rtag(VEC[i].req), "valid", {23'd0, res_valid}, 24'd1);
            check(rtag(VEC[i].req), "branch", {23'd0, res_branch}, {23'd0, VEC[i].br});
            check(rtag(VEC[i].req), "taken", {23'd0, res_taken}, {23'd0, VEC[i].tk});
            check(rtag(VEC[i].req), "target", res_target, VEC[i].tgt);
        end
        idle();
        @(negedge clk);
        check("R2", "valid drop", {23'd0, res_valid}, 24'd0);

        // R10: unused and unrelated flag bits do not move a slot-6 decision
        for (int k = 0; k < 128; k++) begin
            drive(8'h00, 8'h26, 8'h04, 7'(k), 1'(k), 8'(k), 24'h002000);
            @(negedge clk);
            check("R10", "slot6 taken", {23'd0, res_taken}, {23'd0, ~k[1]});
        end
        // R10: high mask bit has no effect on prefixed slot C
        drive(8'h90, 8'h2C, 8'h04, 7'h20, 1'b0, 8'h00, 24'h002000);
        @(negedge clk);
        check("R10", "mask_hi ignored", {23'd0, res_taken}, 24'd1);

        // R1: reset mid-run clears results
        drive(8'h00, 8'h20, 8'h04, 7'h00, 1'b0, 8'h00, 24'h002000);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "mid reset valid", {23'd0, res_valid}, 24'd0);
        check("R1", "mid reset target", res_target, 24'd0);
        rst = 1'b0;
        idle();
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule